// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the slave side of a two-wire serial bus in front of a byte-wide nonvolatile store. The store is a register array, and a cycle counter stands in for the programming time. A host selects the block with a command byte. The command byte carries a 7-bit device identity and a read/write flag. For a write, the host then sends a two-byte word address and up to one page of data bytes. Those bytes are collected in a page buffer and committed to the array only after the stop condition.

While the self-timed commit runs, the block refuses every command byte. A host therefore learns that the write has finished by repeating a command until it is acknowledged. Reads begin either at a freshly loaded address or at the current address pointer. Reads continue byte by byte for as long as the host acknowledges. A write-protect input lets a whole write transaction run on the bus without changing the array.

The bus pins are sampled with the system clock through two-stage synchronizers. SDA is driven only as an open-drain pull-low enable.

Top module: `twi_eeprom`

## Requirements
- R1: A command byte whose upper seven bits equal DEV_ID (default 7'h50) is acknowledged by pulling SDA low during the ninth clock. Bit 0 of the command byte selects read (1) or write (0). A command byte that does not match is not acknowledged, and every further byte up to the next start is ignored and not acknowledged.
- R2: A write command is followed by an address high byte and an address low byte, and the block acknowledges both. The word address is the low MEM_AW bits of {high, low}.
- R3: Data bytes that follow the address are acknowledged and stored in a page of 2**PAGE_W bytes. After each byte, only the low PAGE_W bits of the pointer advance, wrapping inside the page. A byte sent past the page size therefore replaces the one sent a full page earlier.
- R4: A stop that follows at least one data byte starts a write cycle of WR_CLKS clocks, and the array changes only during that cycle. A stop that comes before any data byte starts no write cycle, but the address it delivered becomes the current pointer.
- R5: While a write cycle runs, no command byte is acknowledged and SDA is never pulled low. The first command byte after the cycle ends is acknowledged.
- R6: If wp_i is high at the stop, the data bytes are still acknowledged, but no write cycle starts and the array keeps its contents.
- R7: A random read is a write command, two address bytes, a repeated start and a read command. The block then returns the byte at that address, MSB first.
- R8: While the host acknowledges, each read returns the byte at pointer+1, wrapping from the last array address to 0. A host no-acknowledge followed by stop ends the read, and SDA is released.
- R9: A read command with no address returns the byte at the current pointer. After any byte is read or written, the pointer holds one more than that byte's address.
- R10: sda_pull_o changes only while the synchronized SCL is low.
- R11: After reset, SDA is released and the block waits for a start condition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock from the host |
| sda_i | input | 1 | Level seen on the shared data line |
| wp_i | input | 1 | Write protect, high blocks the commit |
| sda_pull_o | output | 1 | High pulls the data line low |

## Verification
The case that needs the most care is a host poll arriving while the write cycle is still running. In that case the command decode and the busy counter act on the same byte. The bench polls straight after the stop and expects a refusal. It then waits past WR_CLKS and expects an acknowledge. A second overlap comes from a page write longer than the page, where the buffer write and the pointer wrap land on the same slot. The bench reads that page back and compares it with a model that applies the in-page wrap arithmetically.

// File: rtl/twi_eeprom.sv
module twi_eeprom #(
  parameter logic [6:0] DEV_ID  = 7'h50,
  parameter int         MEM_AW  = 11,
  parameter int         PAGE_W  = 6,
  parameter int         WR_CLKS = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_i,
  output logic sda_pull_o
);
  localparam int DEPTH = 1 << MEM_AW;
  localparam int PAGE  = 1 << PAGE_W;
  localparam int CW    = $clog2(WR_CLKS + 1);

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_AHI, S_ALO, S_WDAT, S_RDAT} st_t;

  st_t               st;
  logic [1:0]        scl_sy, sda_sy;
  logic              scl_q, sda_q;
  logic [3:0]        bitn;
  logic [7:0]        sh, ahi;
  logic [MEM_AW-1:0] ptr;
  logic [PAGE-1:0]   mask;
  logic              busy;
  logic [CW-1:0]     wcnt;
  logic [7:0]        mem  [DEPTH];
  logic [7:0]        pbuf [PAGE];

  wire scl_s   = scl_sy[1];
  wire sda_s   = sda_sy[1];
  wire start_c = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c  = scl_s & scl_q & ~sda_q & sda_s;
  wire rise    = scl_s & ~scl_q;
  wire fall    = ~scl_s & scl_q;
  wire in_wdat = (st == S_WDAT);
  wire cmd_ok  = (sh[7:1] == DEV_ID) && !busy;
  wire byte_in = fall && (bitn == 4'd8) && in_wdat;

  wire [PAGE_W-1:0] pofs  = ptr[PAGE_W-1:0];
  wire [PAGE_W-1:0] pnext = pofs + 1'b1;
  wire [PAGE_W-1:0] cofs  = wcnt[PAGE_W-1:0];
  wire [MEM_AW-1:0] cptr  = {ptr[MEM_AW-1:PAGE_W], cofs};
  wire [7:0]        rd_byte = mem[ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy     <= 2'b11;
      sda_sy     <= 2'b11;
      scl_q      <= 1'b1;
      sda_q      <= 1'b1;
      st         <= S_IDLE;
      bitn       <= '0;
      sh         <= '0;
      ahi        <= '0;
      ptr        <= '0;
      mask       <= '0;
      busy       <= 1'b0;
      wcnt       <= '0;
      sda_pull_o <= 1'b0;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;

      if (busy) begin
        if (wcnt == CW'(WR_CLKS - 1)) begin
          busy <= 1'b0;
          wcnt <= '0;
          mask <= '0;
        end else begin
          wcnt <= wcnt + 1'b1;
        end
      end

      if (start_c) begin
        st         <= S_CMD;
        bitn       <= '0;
        sda_pull_o <= 1'b0;
        if (!busy) mask <= '0;
      end else if (stop_c) begin
        st         <= S_IDLE;
        sda_pull_o <= 1'b0;
        if (!busy && |mask && !wp_i) busy <= 1'b1;
        else if (!busy) mask <= '0;
      end else if (st != S_IDLE) begin
        if (rise) begin
          if (bitn == 4'd8) begin
            bitn <= 4'd9;
            if (st == S_RDAT && sda_s) st <= S_IDLE;
          end else begin
            bitn <= bitn + 4'd1;
            if (st != S_RDAT) sh <= {sh[6:0], sda_s};
          end
        end else if (fall) begin
          if (bitn == 4'd9) begin
            bitn <= '0;
            if (st == S_RDAT) begin
              sh         <= rd_byte;
              sda_pull_o <= ~rd_byte[7];
            end else begin
              sda_pull_o <= 1'b0;
            end
          end else if (st == S_RDAT) begin
            if (bitn == 4'd8) begin
              sda_pull_o <= 1'b0;
              ptr        <= ptr + 1'b1;
            end else if (bitn != 4'd0) begin
              sda_pull_o <= ~sh[3'(4'd7 - bitn)];
            end
          end else if (bitn == 4'd8) begin
            sda_pull_o <= 1'b1;
            case (st)
              S_CMD: begin
                if (!cmd_ok) begin
                  sda_pull_o <= 1'b0;
                  st         <= S_IDLE;
                end else begin
                  st <= sh[0] ? S_RDAT : S_AHI;
                end
              end
              S_AHI: begin
                ahi <= sh;
                st  <= S_ALO;
              end
              S_ALO: begin
                ptr <= MEM_AW'({ahi, sh});
                st  <= S_WDAT;
              end
              S_WDAT: begin
                mask[pofs] <= 1'b1;
                ptr        <= {ptr[MEM_AW-1:PAGE_W], pnext};
              end
              default: ;
            endcase
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (busy && wcnt < CW'(PAGE) && mask[cofs]) mem[cptr] <= pbuf[cofs];
    if (byte_in) pbuf[pofs] <= sh;
  end
endmodule

module twi_eeprom_chk #(
  parameter int HW = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          pull,
  input logic          busy,
  input logic          wp,
  input logic          mask_any,
  input logic          in_wdat,
  input logic [HW-1:0] page
);
  a_r10_pull_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (pull != $past(pull)) |-> !$past(scl_s));

  a_r5_busy_silent: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !pull);

  a_r6_wp_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(wp));

  a_r4_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(mask_any));

  a_r3_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wdat && $past(in_wdat)) |-> $stable(page));
endmodule

bind twi_eeprom twi_eeprom_chk #(.HW(MEM_AW - PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .pull(sda_pull_o), .busy(busy),
  .wp(wp_i), .mask_any(|mask), .in_wdat(in_wdat),
  .page(ptr[MEM_AW-1:PAGE_W])
);

// File: tb/tb_twi_eeprom.sv
module tb_twi_eeprom;
  localparam int AW = 8, PW = 4, TW = 400, Q = 8;
  localparam int DEPTH = 1 << AW, PAGE = 1 << PW;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic pull;
  wire  sda_line = sda_m & ~pull;

  twi_eeprom #(.MEM_AW(AW), .PAGE_W(PW), .WR_CLKS(TW)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .wp_i(wp), .sda_pull_o(pull));

  always #2 clk = ~clk;

  int checks = 0, errors = 0, r10_bad = 0;
  bit done = 1'b0;
  logic [7:0] exp_m [DEPTH];
  logic [7:0] wbuf [32];
  logic [7:0] rbuf [300];
  logic prev_pull = 1'b0;

  always @(posedge clk) begin
    if (rst_n && pull !== prev_pull && scl) r10_bad++;
    prev_pull <= pull;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; tick(Q/2); scl = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q/2);
  endtask

  task automatic i2c_stop();
    tick(Q/2); sda_m = 1'b0; tick(Q/2); scl = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic wbyte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      tick(Q/2); sda_m = b[i]; tick(Q/2); scl = 1'b1; tick(Q); scl = 1'b0;
    end
    tick(Q/2); sda_m = 1'b1; tick(Q/2); scl = 1'b1; tick(Q/2);
    ack = (sda_line == 1'b0);
    tick(Q/2); scl = 1'b0;
  endtask

  task automatic rbyte(output logic [7:0] b, input bit mack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl = 1'b1; tick(Q/2); b[i] = sda_line; tick(Q/2); scl = 1'b0;
    end
    tick(Q/2); sda_m = mack ? 1'b0 : 1'b1; tick(Q/2); scl = 1'b1; tick(Q); scl = 1'b0;
    tick(Q/2); sda_m = 1'b1;
  endtask

  task automatic poll(output bit ack);
    i2c_start(); wbyte(8'hA0, ack); i2c_stop();
  endtask

  task automatic wr_txn(input int addr, input int n, output int acks);
    bit a;
    acks = 0;
    i2c_start();
    wbyte(8'hA0, a); acks += int'(a);
    wbyte(8'h00, a); acks += int'(a);
    wbyte(8'(addr), a); acks += int'(a);
    for (int i = 0; i < n; i++) begin wbyte(wbuf[i], a); acks += int'(a); end
    i2c_stop();
  endtask

  task automatic rd_seq(input int addr, input int n, output int acks);
    bit a;
    acks = 0;
    i2c_start();
    wbyte(8'hA0, a); acks += int'(a);
    wbyte(8'h00, a); acks += int'(a);
    wbyte(8'(addr), a); acks += int'(a);
    i2c_start();
    wbyte(8'hA1, a); acks += int'(a);
    for (int i = 0; i < n; i++) rbyte(rbuf[i], i < n - 1);
    i2c_stop();
  endtask

  task automatic cur_seq(input int n, output int acks);
    bit a;
    i2c_start();
    wbyte(8'hA1, a); acks = int'(a);
    for (int i = 0; i < n; i++) rbyte(rbuf[i], i < n - 1);
    i2c_stop();
  endtask

  task automatic model_page(input int addr, input int n);
    for (int i = 0; i < n; i++)
      exp_m[(addr & ~(PAGE - 1)) | (((addr % PAGE) + i) % PAGE)] = wbuf[i];
  endtask

  task automatic finish_run();
    chk("R10", r10_bad, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    int acks;
    bit a;
    tick(5); rst_n = 1'b1; tick(5);
    chk("R11 reset release", pull, 0);

    // R2 R4: fill whole array page by page
    for (int p = 0; p < DEPTH / PAGE; p++) begin
      for (int i = 0; i < PAGE; i++) wbuf[i] = 8'((p * PAGE + i) * 13 + 7);
      wr_txn(p * PAGE, PAGE, acks);
      chk("R2 page acks", acks, PAGE + 3);
      model_page(p * PAGE, PAGE);
      tick(TW + 50);
      poll(a);
      chk("R5 ack after cycle", a, 1);
    end

    // R7 R8: random read from 0 through the wrap
    rd_seq(0, DEPTH + 1, acks);
    chk("R7 read acks", acks, 4);
    chk("R7 first byte", rbuf[0], exp_m[0]);
    for (int i = 1; i <= DEPTH; i++) chk("R8 sequential", rbuf[i], exp_m[i % DEPTH]);
    tick(4);
    chk("R8 released", pull, 0);

    // R9: current address read continues at pointer
    cur_seq(2, acks);
    chk("R9 ack", acks, 1);
    chk("R9 byte0", rbuf[0], exp_m[(DEPTH + 1) % DEPTH]);
    chk("R9 byte1", rbuf[1], exp_m[(DEPTH + 2) % DEPTH]);

    // R3 R5: over-long page write wraps in page
    for (int i = 0; i < PAGE + 2; i++) wbuf[i] = 8'(8'h80 + i);
    wr_txn(8'h2E, PAGE + 2, acks);
    chk("R3 acks", acks, PAGE + 5);
    model_page(8'h2E, PAGE + 2);
    poll(a);
    chk("R5 busy nack", a, 0);
    tick(TW);
    poll(a);
    chk("R5 done ack", a, 1);
    rd_seq(8'h20, PAGE, acks);
    for (int i = 0; i < PAGE; i++) chk("R3 wrapped page", rbuf[i], exp_m[8'h20 + i]);

    // R6: write protect
    wp = 1'b1;
    for (int i = 0; i < 4; i++) wbuf[i] = 8'h55;
    wr_txn(8'h40, 4, acks);
    chk("R6 acks", acks, 7);
    poll(a);
    chk("R6 no cycle", a, 1);
    wp = 1'b0;
    rd_seq(8'h40, 4, acks);
    for (int i = 0; i < 4; i++) chk("R6 unchanged", rbuf[i], exp_m[8'h40 + i]);

    // R1: foreign device identity
    i2c_start();
    wbyte(8'hA4, a); chk("R1 cmd nack", a, 0);
    wbyte(8'h00, a); chk("R1 ignored", a, 0);
    wbyte(8'h10, a); chk("R1 ignored", a, 0);
    wbyte(8'hEE, a); chk("R1 ignored", a, 0);
    i2c_stop();
    poll(a);
    chk("R1 no cycle", a, 1);
    rd_seq(8'h10, 1, acks);
    chk("R1 unchanged", rbuf[0], exp_m[8'h10]);

    // R4 R9: address only, then current read
    i2c_start();
    wbyte(8'hA0, a); wbyte(8'h00, a); wbyte(8'h77, a);
    i2c_stop();
    poll(a);
    chk("R4 no cycle without data", a, 1);
    cur_seq(1, acks);
    chk("R9 pointer from address", rbuf[0], exp_m[8'h77]);

    // R8: wrap from top of array
    rd_seq(DEPTH - 2, 3, acks);
    chk("R8 top-1", rbuf[0], exp_m[DEPTH - 2]);
    chk("R8 top", rbuf[1], exp_m[DEPTH - 1]);
    chk("R8 wrap", rbuf[2], exp_m[0]);

    done = 1'b1;
    finish_run();
  end
endmodule